// File: doc/BRIEF.md
# Health-Gated Priority Reference Selector

This block chooses which of several timing references drives a clock subsystem. Every reference arrives with four health verdicts, produced elsewhere, that say whether its frequency offset sits inside the capture window, whether it is free of sudden phase jumps, whether its short-term noise is steady, and whether its pulses or packets arrive without gaps. A reference becomes a candidate only when all four verdicts are good. Software gives each reference a priority, but priority is only applied among the candidates: a preferred reference that fails any verdict is ignored.

All decisions are taken on evaluation ticks. A lost active reference is replaced on the same tick by the best remaining candidate. A better candidate, however, must remain the best for a programmable number of consecutive ticks before it takes over, so two references that keep trading health cannot make the selection oscillate. A force input pins the selection to one reference while still honouring its health. The block reports the active index, a valid flag, a one-cycle switch strobe with a cause code, and for each reference its candidacy and the first failing verdict.

Top module: `hgate_ref_selector`

## Requirements
- R1: Reference i is eligible exactly when all four bits gate_ok[4i+3:4i] are 1 (bit 0 frequency offset, bit 1 phase step, bit 2 noise, bit 3 continuity). A continuity failure alone makes it ineligible whatever the other bits say.
- R2: fail_gate[2i+1:2i] gives the lowest-numbered failing verdict bit of reference i, and gives 0 when the reference is eligible.
- R3: When nothing is selected and force_en is low, a tick selects the eligible reference with the largest prio_cfg[2i+1:2i] value (3 is the most preferred). Equal values go to the lower index. The cause code is 1 (acquire).
- R4: While the active reference stays eligible, a more preferred eligible reference takes over only after it has been the best candidate on WIN consecutive ticks. It switches on the WIN-th such tick with cause 2 (upgrade). A tick on which it is not the best candidate restarts the count.
- R5: When the active reference is ineligible at a tick, the best eligible reference is selected on that tick with no waiting window, with cause 3 (failover).
- R6: When no reference is eligible and force_en is low, active_valid goes low with cause 4 (lost).
- R7: With force_en high and reference force_idx eligible, that reference is selected regardless of priority, with cause 5 (forced).
- R8: With force_en high and reference force_idx ineligible, active_valid is low with cause 6 (forced ineligible), even if other references are eligible.
- R9: The selection changes only on ticks. Outputs are registered and appear in the cycle after the tick is sampled. switch_pulse is high for that one cycle only when active_valid or (while valid) active_idx changes. Cause codes 4 and 6 are also posted on ticks that leave the block unselected.
- R10: After reset active_valid is 0, active_idx is 0, switch_pulse is 0 and switch_reason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Evaluation tick; decisions are taken only when high |
| gate_ok | input | 16 | Four health verdicts per reference, 1 = good |
| prio_cfg | input | 8 | Two-bit priority per reference, larger wins |
| force_en | input | 1 | Force the selection to force_idx |
| force_idx | input | 2 | Reference to force |
| active_idx | output | 2 | Selected reference |
| active_valid | output | 1 | A reference is selected |
| switch_pulse | output | 1 | One-cycle strobe on a change of selection |
| switch_reason | output | 3 | Cause of the last selection event |
| eligible | output | 4 | Per-reference candidacy |
| fail_gate | output | 8 | Per-reference lowest failing verdict index |

## Verification
On every cycle the assertions check the following. Outputs hold between ticks. A strobe never arrives without a tick and never carries cause 0. An ineligible active reference always produces a strobe on the next cycle. A forced ineligible reference always leaves the block unselected. The reported failing verdict is really a failing one. An upgrade fires only after the counter has seen the same candidate for the whole window. Only the bench scenarios can show that the right reference wins. That covers the full sweep of priority orderings against eligibility masks, tie-breaking, the window restart after a candidate briefly drops out, and the precise tick on which an upgrade lands.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int GATE_N     = 4;
    localparam int GATE_IDX_W = 2;

    typedef enum logic [2:0] {
        RSN_NONE       = 3'd0,
        RSN_ACQUIRE    = 3'd1,
        RSN_UPGRADE    = 3'd2,
        RSN_FAILOVER   = 3'd3,
        RSN_LOST       = 3'd4,
        RSN_FORCED     = 3'd5,
        RSN_FORCED_BAD = 3'd6
    } sel_reason_e;

    typedef struct packed {
        logic                  ok;
        logic [GATE_IDX_W-1:0] fail_gate;
    } gate_verdict_t;

    function automatic logic [GATE_IDX_W-1:0] lowest_fail(input logic [GATE_N-1:0] g);
        logic [GATE_IDX_W-1:0] r;
        r = '0;
        for (int k = GATE_N - 1; k >= 0; k--) begin
            if (!g[k]) r = k[GATE_IDX_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/refsel_gate_check.sv
module refsel_gate_check
    import refsel_pkg::*;
(
    input  logic [GATE_N-1:0] gates,
    output gate_verdict_t     verdict
);

    always_comb begin
        verdict.ok        = &gates;
        verdict.fail_gate = verdict.ok ? '0 : lowest_fail(gates);
    end

    // R2: the reported verdict index must point at a bit that is actually bad
    always_comb begin
        if (!$isunknown(gates) && !verdict.ok) begin
            assert_fail_gate_real_R2: assert (!gates[verdict.fail_gate]);
        end
    end

endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
    parameter int N_REF  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [N_REF-1:0]        elig,
    input  logic [N_REF*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]        best_idx,
    output logic                    best_any
);

    logic [PRIO_W-1:0] best_p;

    // strict compare keeps the lower index on equal priority
    always_comb begin
        best_any = 1'b0;
        best_idx = '0;
        best_p   = '0;
        for (int i = 0; i < N_REF; i++) begin
            if (elig[i] && (!best_any || prio[i*PRIO_W +: PRIO_W] > best_p)) begin
                best_any = 1'b1;
                best_idx = i[IDX_W-1:0];
                best_p   = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R3: the chosen reference is always a candidate
    always_comb begin
        if (!$isunknown(elig) && best_any) begin
            assert_best_is_eligible_R3: assert (elig[best_idx]);
        end
    end

endmodule

// File: rtl/refsel_window.sv
module refsel_window #(
    parameter int IDX_W = 2,
    parameter int WIN   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic             cand_ok,
    input  logic [IDX_W-1:0] cand_idx,
    output logic             ripe
);

    localparam int             CW    = $clog2(WIN + 1);
    localparam logic [CW-1:0]  WIN_C = CW'(WIN);

    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    cnt_nx;
    logic [IDX_W-1:0] cand_q;
    logic             run_q;

    always_comb begin
        cnt_nx = (run_q && cand_idx == cand_q) ? cnt_q + 1'b1 : CW'(1);
        ripe   = eval && cand_ok && (cnt_nx >= WIN_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cand_q <= '0;
            run_q  <= 1'b0;
        end else if (eval) begin
            if (!cand_ok || ripe) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_nx;
                cand_q <= cand_idx;
                run_q  <= 1'b1;
            end
        end
    end

    // R4: a running count never reaches the window without firing
    assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q < WIN_C);

    // R4: firing requires the same candidate counted through the earlier ticks
    assert_window_full_R4: assert property (@(posedge clk) disable iff (rst)
        (ripe && WIN > 1) |-> (run_q && cand_q == cand_idx && cnt_q == WIN_C - 1'b1));

endmodule

// File: rtl/hgate_ref_selector.sv
module hgate_ref_selector
    import refsel_pkg::*;
#(
    parameter int N_REF  = 4,
    parameter int PRIO_W = 2,
    parameter int WIN    = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tick,
    input  logic [N_REF*GATE_N-1:0]      gate_ok,
    input  logic [N_REF*PRIO_W-1:0]      prio_cfg,
    input  logic                         force_en,
    input  logic [$clog2(N_REF)-1:0]     force_idx,
    output logic [$clog2(N_REF)-1:0]     active_idx,
    output logic                         active_valid,
    output logic                         switch_pulse,
    output logic [2:0]                   switch_reason,
    output logic [N_REF-1:0]             eligible,
    output logic [N_REF*GATE_IDX_W-1:0]  fail_gate
);

    localparam int IDX_W = $clog2(N_REF);

    gate_verdict_t verdicts [N_REF];

    for (genvar g = 0; g < N_REF; g++) begin : g_gate
        refsel_gate_check u_chk (
            .gates   (gate_ok[g*GATE_N +: GATE_N]),
            .verdict (verdicts[g])
        );
        assign eligible[g]                              = verdicts[g].ok;
        assign fail_gate[g*GATE_IDX_W +: GATE_IDX_W]    = verdicts[g].fail_gate;
    end

    logic [IDX_W-1:0] best_idx;
    logic             best_any;

    refsel_pick #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .elig     (eligible),
        .prio     (prio_cfg),
        .best_idx (best_idx),
        .best_any (best_any)
    );

    logic             valid_q;
    logic [IDX_W-1:0] idx_q;
    sel_reason_e      reason_q;
    logic             pulse_q;

    logic             cand_ok;
    logic             ripe;

    assign cand_ok = valid_q && eligible[idx_q] && !force_en && best_any && (best_idx != idx_q);

    refsel_window #(.IDX_W(IDX_W), .WIN(WIN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .eval     (tick),
        .cand_ok  (cand_ok),
        .cand_idx (best_idx),
        .ripe     (ripe)
    );

    logic             valid_nx;
    logic [IDX_W-1:0] idx_nx;
    sel_reason_e      reason_nx;
    logic             pulse_nx;

    always_comb begin
        valid_nx  = valid_q;
        idx_nx    = idx_q;
        reason_nx = reason_q;
        if (force_en) begin
            if (eligible[force_idx]) begin
                valid_nx = 1'b1;
                idx_nx   = force_idx;
                if (!valid_q || idx_q != force_idx) reason_nx = RSN_FORCED;
            end else begin
                valid_nx  = 1'b0;
                reason_nx = RSN_FORCED_BAD;
            end
        end else if (!valid_q) begin
            if (best_any) begin
                valid_nx  = 1'b1;
                idx_nx    = best_idx;
                reason_nx = RSN_ACQUIRE;
            end else begin
                reason_nx = RSN_LOST;
            end
        end else if (!eligible[idx_q]) begin
            if (best_any) begin
                idx_nx    = best_idx;
                reason_nx = RSN_FAILOVER;
            end else begin
                valid_nx  = 1'b0;
                reason_nx = RSN_LOST;
            end
        end else if (ripe) begin
            idx_nx    = best_idx;
            reason_nx = RSN_UPGRADE;
        end
        pulse_nx = tick && ((valid_nx != valid_q) || (valid_nx && idx_nx != idx_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            idx_q    <= '0;
            reason_q <= RSN_NONE;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= pulse_nx;
            if (tick) begin
                valid_q  <= valid_nx;
                idx_q    <= idx_nx;
                reason_q <= reason_nx;
            end
        end
    end

    assign active_valid  = valid_q;
    assign active_idx    = idx_q;
    assign switch_reason = reason_q;
    assign switch_pulse  = pulse_q;

    // R9: nothing moves between ticks
    assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(active_idx) && $stable(active_valid) && !switch_pulse));

    // R9: every strobe carries a cause
    assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        switch_pulse |-> (switch_reason != 3'd0));

    // R5: a selected reference that fails at a tick is always replaced or dropped
    assert_failover_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && active_valid && !eligible[active_idx]) |=> switch_pulse);

    // R8: forcing an unhealthy reference leaves nothing selected
    assert_forced_bad_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && force_en && !eligible[force_idx]) |=> (!active_valid && switch_reason == 3'd6));

endmodule

// File: tb/hgate_ref_selector_tb.sv
module hgate_ref_selector_tb;

    localparam int WIN = 4;

    localparam int C_NONE = 0, C_ACQ = 1, C_UPG = 2, C_FAIL = 3, C_LOST = 4, C_FRC = 5, C_FBAD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [15:0] gate_ok = '0;
    logic [7:0]  prio_cfg = '0;
    logic        force_en = 1'b0;
    logic [1:0]  force_idx = '0;
    logic [1:0]  active_idx;
    logic        active_valid;
    logic        switch_pulse;
    logic [2:0]  switch_reason;
    logic [3:0]  eligible;
    logic [7:0]  fail_gate;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hgate_ref_selector #(.N_REF(4), .PRIO_W(2), .WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .gate_ok(gate_ok), .prio_cfg(prio_cfg),
        .force_en(force_en), .force_idx(force_idx), .active_idx(active_idx),
        .active_valid(active_valid), .switch_pulse(switch_pulse),
        .switch_reason(switch_reason), .eligible(eligible), .fail_gate(fail_gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        #1;
    endtask

    task automatic sel(input string tag, input int v, input int idx, input int why, input int pl);
        chk({tag, " valid"}, active_valid, v);
        if (v != 0) chk({tag, " idx"}, active_idx, idx);
        chk({tag, " reason"}, switch_reason, why);
        chk({tag, " pulse"}, switch_pulse, pl);
    endtask

    function automatic logic [15:0] mask_gates(input logic [3:0] m);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[4*i +: 4] = m[i] ? 4'hF : 4'h0;
        return r;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        sel("R10 reset", 0, 0, C_NONE, 0);
        chk("R10 reset idx", active_idx, 0);

        // priorities: ref3=3, ref2=2, ref1=1, ref0=0
        prio_cfg = 8'hE4;
        gate_ok  = mask_gates(4'b0001);
        tk(); sel("R3 acquire lone", 1, 0, C_ACQ, 1);
        @(negedge clk); #1; chk("R9 pulse one cycle", switch_pulse, 0);

        // upgrade to ref2 after WIN ticks
        gate_ok = mask_gates(4'b0101);
        for (int t = 1; t < WIN; t++) begin
            tk(); sel("R4 window wait", 1, 0, C_ACQ, 0);
        end
        tk(); sel("R4 upgrade", 1, 2, C_UPG, 1);

        // restart: ref3 good two ticks, continuity drops once, then good again
        gate_ok = mask_gates(4'b1101);
        tk(); tk(); sel("R4 partial window", 1, 2, C_UPG, 0);
        gate_ok[15] = 1'b0; #1;
        chk("R1 continuity alone", eligible[3], 0);
        tk(); sel("R4 dropout", 1, 2, C_UPG, 0);
        gate_ok[15] = 1'b1;
        for (int t = 1; t < WIN; t++) begin
            tk(); sel("R4 restarted wait", 1, 2, C_UPG, 0);
        end
        tk(); sel("R4 upgrade after restart", 1, 3, C_UPG, 1);

        // no tick: nothing moves
        gate_ok = mask_gates(4'b0101);
        repeat (5) @(negedge clk); #1;
        sel("R9 no tick", 1, 3, C_UPG, 0);

        tk(); sel("R5 failover", 1, 2, C_FAIL, 1);

        force_en = 1'b1; force_idx = 2'd0;
        tk(); sel("R7 forced", 1, 0, C_FRC, 1);
        tk(); sel("R9 forced hold", 1, 0, C_FRC, 0);
        force_idx = 2'd3;
        tk(); sel("R8 forced ineligible", 0, 0, C_FBAD, 1);
        tk(); sel("R8 forced ineligible hold", 0, 0, C_FBAD, 0);

        force_en = 1'b0;
        tk(); sel("R3 reacquire", 1, 2, C_ACQ, 1);
        gate_ok = '0;
        tk(); sel("R6 lost", 0, 0, C_LOST, 1);
        tk(); sel("R6 stays lost", 0, 0, C_LOST, 0);

        // tie goes to the lower index
        prio_cfg = 8'h55;
        gate_ok  = mask_gates(4'b1010);
        tk(); sel("R3 tie", 1, 1, C_ACQ, 1);

        // R1/R2 sweep of every verdict pattern on every reference
        for (int i = 0; i < 4; i++) begin
            for (int p = 0; p < 16; p++) begin
                int lz;
                gate_ok = 16'hFFFF;
                gate_ok[4*i +: 4] = p[3:0];
                #1;
                lz = 0;
                for (int k = 3; k >= 0; k--) if (!p[k]) lz = k;
                chk("R1 eligible sweep", eligible[i], (p == 15) ? 1 : 0);
                chk("R2 fail gate sweep", fail_gate[2*i +: 2], lz);
            end
        end

        // R3 sweep: every priority permutation against every eligibility mask
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                int pr [4];
                pr[0] = a; pr[1] = b; pr[2] = c; pr[3] = d;
                prio_cfg = {d[1:0], c[1:0], b[1:0], a[1:0]};
                for (int m = 0; m < 16; m++) begin
                    int best;
                    gate_ok = '0;
                    tk();
                    gate_ok = mask_gates(m[3:0]);
                    tk();
                    best = -1;
                    for (int i = 0; i < 4; i++)
                        if (m[i] && (best < 0 || pr[i] > pr[best])) best = i;
                    if (best < 0) sel("R6 sweep none", 0, 0, C_LOST, 0);
                    else          sel("R3 sweep pick", 1, best, C_ACQ, 1);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule